// File: doc/BRIEF.md
# Masked priority interrupt resolver

This block decides which interrupt line to report to a processor. It receives, for every line, a pending bit, a mask bit, a class bit choosing the fast or the normal request path, and a 5-bit urgency level. A class input selects which of the two paths is being resolved. From the lines that take part, the block reports the number of the most urgent one and a flag that says whether any line took part at all.

Lines are grouped in banks of 32, and a parameter sets how many banks there are (1 to 3). Line numbers run across all banks. The selection logic is purely combinational. Its result is captured in one output register, so the outputs reflect the inputs that were present at the previous rising clock edge. Storage of pending bits, the register interface and the request handshake toward the processor belong to neighbouring blocks.

Top module: `irq_resolver`

## Requirements
- R1: A line takes part only when its pending bit is 1, its mask bit is 0 and its class bit equals `class_i` (1 selects the fast class, 0 the normal class). A line that is masked, not pending or of the other class never affects the outputs.
- R2: Among the lines that take part, the line with the smallest urgency value wins. Value 0 is the most urgent and 31 the least urgent.
- R3: When several lines inside one bank that take part share the best urgency value, the line with the highest bit index wins.
- R4: The reported number is 32 times the bank index plus the bit index. Bank b occupies bits [32b+31:32b] of the line vectors and bits [160b+5k+4:160b+5k] of `prio_i` hold line k of that bank. On a tie across banks, the higher bank wins.
- R5: When no line takes part, `line_o` is 0.
- R6: `valid_o` is 1 exactly when at least one line takes part. This lets a real line 0 be told apart from the case with no winner.
- R7: The outputs change only at a rising clock edge and show the result for the inputs sampled at that edge. The latency is one cycle.
- R8: A synchronous active-high `rst` clears `line_o` and `valid_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| class_i | input | 1 | Class being resolved: 1 fast, 0 normal |
| pend_i | input | 32*NBANKS | Pending bit per line |
| mask_i | input | 32*NBANKS | Mask bit per line, 1 blocks the line |
| fast_i | input | 32*NBANKS | Class bit per line, 1 fast |
| prio_i | input | 160*NBANKS | 5-bit urgency per line, 0 most urgent |
| line_o | output | 7 | Winning line number, registered |
| valid_o | output | 1 | Some line takes part, registered |

## Verification
On every cycle, the assertions check the following: the winner takes part, no line that takes part is more urgent than the winner, and an equally urgent line never has a higher number than the winner. They also check that the flag follows the eligible set one cycle later and that an empty result reports line 0. Other properties can only be shown by the bench's scenarios, because they concern the input patterns applied. These include which class is resolved, that masked lines are ignored, the tie rules across bank boundaries, and that line 0 can win while the flag is set.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;
  localparam int LANES  = 32;
  localparam int PRIO_W = 5;
  localparam int LINE_W = 7;

  typedef struct packed {
    logic              vld;
    logic [PRIO_W-1:0] prio;
    logic [LINE_W-1:0] line;
  } cand_t;

  // Pick between two candidates; hi covers the higher line numbers and wins ties.
  function automatic cand_t pick(input cand_t lo, input cand_t hi);
    if (hi.vld && (!lo.vld || hi.prio <= lo.prio)) return hi;
    return lo;
  endfunction
endpackage

// File: rtl/irq_bank_pick.sv
module irq_bank_pick
  import irq_resolver_pkg::*;
#(
  parameter int BANK_IDX = 0
) (
  input  logic                    class_i,
  input  logic [LANES-1:0]        pend_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic [LANES-1:0]        fast_i,
  input  logic [LANES*PRIO_W-1:0] prio_i,
  output logic [LANES-1:0]        elig_o,
  output cand_t                   best_o
);
  localparam int NODES = 2*LANES - 1;
  localparam int FIRST_LEAF = LANES - 1;

  cand_t node [NODES];

  // Leaves: one candidate per line, in ascending line order.
  for (genvar b = 0; b < LANES; b++) begin : g_leaf
    assign elig_o[b] = pend_i[b] & ~mask_i[b] & (fast_i[b] == class_i);
    assign node[FIRST_LEAF+b].vld  = elig_o[b];
    assign node[FIRST_LEAF+b].prio = prio_i[b*PRIO_W +: PRIO_W];
    assign node[FIRST_LEAF+b].line = LINE_W'(BANK_IDX*LANES + b);
  end

  // Balanced tree: right child always spans the higher line numbers.
  for (genvar n = 0; n < FIRST_LEAF; n++) begin : g_node
    assign node[n] = pick(node[2*n+1], node[2*n+2]);
  end

  assign best_o = node[0];
endmodule

// File: rtl/irq_bank_merge.sv
module irq_bank_merge
  import irq_resolver_pkg::*;
#(
  parameter int NBANKS = 3
) (
  input  cand_t bank_i [NBANKS],
  output cand_t win_o
);
  always_comb begin
    win_o = bank_i[0];
    for (int b = 1; b < NBANKS; b++) begin
      win_o = pick(win_o, bank_i[b]);
    end
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_resolver_pkg::*;
#(
  parameter int NBANKS = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           class_i,
  input  logic [NBANKS*LANES-1:0]        pend_i,
  input  logic [NBANKS*LANES-1:0]        mask_i,
  input  logic [NBANKS*LANES-1:0]        fast_i,
  input  logic [NBANKS*LANES*PRIO_W-1:0] prio_i,
  output logic [LINE_W-1:0]              line_o,
  output logic                           valid_o
);
  localparam int NLINES = NBANKS * LANES;
  localparam int BANK_PW = LANES * PRIO_W;

  cand_t                bank_best [NBANKS];
  logic  [NLINES-1:0]   elig_all;
  cand_t                win;

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    irq_bank_pick #(.BANK_IDX(g)) i_pick (
      .class_i (class_i),
      .pend_i  (pend_i[g*LANES +: LANES]),
      .mask_i  (mask_i[g*LANES +: LANES]),
      .fast_i  (fast_i[g*LANES +: LANES]),
      .prio_i  (prio_i[g*BANK_PW +: BANK_PW]),
      .elig_o  (elig_all[g*LANES +: LANES]),
      .best_o  (bank_best[g])
    );
  end

  irq_bank_merge #(.NBANKS(NBANKS)) i_merge (
    .bank_i (bank_best),
    .win_o  (win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= win.vld;
      line_o  <= win.vld ? win.line : '0;
    end
  end

  // Combinational checks on the selected candidate against every line.
  always_comb begin
    if (!rst && win.vld) begin
      // R1
      win_elig_chk: assert (elig_all[win.line]);
      for (int k = 0; k < NLINES; k++) begin
        if (elig_all[k]) begin
          // R2
          prio_order_chk: assert (prio_i[k*PRIO_W +: PRIO_W] >= win.prio);
          // R3
          tie_high_chk: assert (prio_i[k*PRIO_W +: PRIO_W] != win.prio || k <= int'(win.line));
        end
      end
    end
  end

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> line_o == '0);
  // R4
  line_range_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> int'(line_o) < NLINES);
  // R6
  flag_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> valid_o == $past(|elig_all));
  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_o && line_o == '0));
endmodule

// File: tb/test_irq_resolver.sv
module test_irq_resolver;
  localparam int NB = 3;
  localparam int N  = NB * 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              class_i = 1'b0;
  logic [N-1:0]      pend_i = '0;
  logic [N-1:0]      mask_i = '1;
  logic [N-1:0]      fast_i = '0;
  logic [N*5-1:0]    prio_i = '0;
  logic [6:0]        line_o;
  logic              valid_o;

  int n_vec = 0;
  int n_bad = 0;
  int exp_line = 0;
  bit exp_vld = 1'b0;

  always #10 clk = ~clk;

  irq_resolver #(.NBANKS(NB)) i_irq_resolver (
    .clk(clk), .rst(rst), .class_i(class_i), .pend_i(pend_i), .mask_i(mask_i),
    .fast_i(fast_i), .prio_i(prio_i), .line_o(line_o), .valid_o(valid_o)
  );

  function automatic void model();
    int best = 99;
    exp_line = 0;
    exp_vld  = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (pend_i[k] && !mask_i[k] && fast_i[k] == class_i) begin
        if (int'(prio_i[k*5 +: 5]) <= best) begin
          best = int'(prio_i[k*5 +: 5]);
          exp_line = k;
          exp_vld = 1'b1;
        end
      end
    end
  endfunction

  task automatic compare(string tag, int el, bit ev);
    n_vec++;
    if (int'(line_o) != el || valid_o != ev) begin
      n_bad++;
      $display("FAIL %s: line=%0d valid=%0b expected line=%0d valid=%0b",
               tag, line_o, valid_o, el, ev);
    end
  endtask

  // Inputs already set at a falling edge; register them and check.
  task automatic run(string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    compare(tag, exp_line, exp_vld);
  endtask

  task automatic clear_all();
    pend_i = '0; mask_i = '0; fast_i = '0; prio_i = '0; class_i = 1'b0;
  endtask

  task automatic set_prio(int k, int p);
    prio_i[k*5 +: 5] = 5'(p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R8 reset", 0, 1'b0);

    // Eligible line presented during reset must not appear.
    clear_all(); pend_i[40] = 1'b1; set_prio(40, 3);
    @(posedge clk); @(negedge clk);
    compare("R8 held in reset", 0, 1'b0);
    rst = 1'b0;

    run("R1 single line");

    // R7: new inputs show up only after the next rising edge.
    clear_all(); pend_i[5] = 1'b1;
    #1 compare("R7 before edge", 40, 1'b1);
    run("R7 after edge");

    clear_all(); pend_i[0] = 1'b1; set_prio(0, 31);
    run("R6 line zero valid");

    clear_all(); pend_i = '1; mask_i = '1;
    run("R5 all masked");

    clear_all(); pend_i[10] = 1'b1; pend_i[20] = 1'b1; mask_i[10] = 1'b1;
    set_prio(10, 0); set_prio(20, 9);
    run("R1 masked more urgent line ignored");

    clear_all(); pend_i[10] = 1'b1; pend_i[20] = 1'b1; fast_i[10] = 1'b1;
    set_prio(10, 0); set_prio(20, 9);
    run("R1 normal class");
    class_i = 1'b1;
    run("R1 fast class");

    clear_all(); pend_i[30] = 1'b1; pend_i[2] = 1'b1; set_prio(30, 7); set_prio(2, 6);
    run("R2 lower value wins");

    clear_all(); pend_i[3] = 1'b1; pend_i[17] = 1'b1; pend_i[9] = 1'b1;
    set_prio(3, 4); set_prio(17, 4); set_prio(9, 4);
    run("R3 tie highest index");

    clear_all(); pend_i[31] = 1'b1; pend_i[33] = 1'b1; pend_i[64] = 1'b1;
    set_prio(31, 12); set_prio(33, 12); set_prio(64, 12);
    run("R4 tie higher bank");

    clear_all(); pend_i[95] = 1'b1; pend_i[70] = 1'b1; set_prio(95, 2); set_prio(70, 1);
    run("R4 line numbering bank two");

    clear_all(); pend_i = '1; fast_i = '1;
    run("R5 other class only");

    for (int v = 0; v < 3000; v++) begin
      class_i = 1'($urandom);
      for (int w = 0; w < NB; w++) begin
        pend_i[w*32 +: 32] = $urandom & $urandom;
        mask_i[w*32 +: 32] = $urandom | $urandom;
        fast_i[w*32 +: 32] = $urandom;
      end
      for (int k = 0; k < N; k++) prio_i[k*5 +: 5] = (v % 4 == 0) ? 5'($urandom % 2) : 5'($urandom);
      run("R2,R3 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule